// File: doc/BRIEF.md
# Multi-Mode UART Baud Timing Generator

This block supplies the bit timing for a 16550-style serial port that also has high-speed oversampling modes. A small byte-wide register port holds a 16-bit clock divisor, a two-bit oversampling mode, a programmable tick count and a programmable sampling instant. The two divisor bytes share addresses with other port registers. They can be reached only while the latch-access bit (bit 7) of the line control register is set.

From the system clock the block produces three outputs. The first is an oversample tick, issued once every `divisor` clocks. The second is a bit-boundary strobe on the last tick of each bit period. The third is a sample strobe on the tick chosen as the receive sampling instant. The transmit and receive shifters of the serial port use these pulses. Writing a divisor byte or the mode register restarts both internal counters, so the new timing begins from a clean phase.

Top module: `uart_baud_timer`

## Requirements
- R1: After reset, reads return line control 0x00, divisor 0x0001, mode 0, tick count 0x00 and sample point 0xFF. Register addresses are: 0 = divisor low, 1 = divisor high (both only while bit 7 of line control is set), 3 = line control, 4 = mode (bits 1:0), 5 = tick count, 6 = sample point.
- R2: A write to address 0 or 1 while line-control bit 7 is clear leaves the divisor unchanged. While bit 7 is clear, reads of those addresses return 0.
- R3: One oversample tick is issued every D system clocks, where D is the divisor. A divisor of 0 acts as 1.
- R4: In mode 0, and in the reserved mode 1, a bit period is 16 ticks. The bit strobe comes with the 16th tick and the sample strobe with tick index 7 (counting from 0).
- R5: In mode 2 a bit period is 4 ticks, with the sample strobe on tick index 1.
- R6: In mode 3 a bit period is (tick count + 1) ticks, and the sample strobe comes on the tick whose index equals the sample point. A sample point at or beyond the period never fires.
- R7: In modes 0, 1 and 2 the sample point register has no effect on the strobes.
- R8: A write to either divisor byte (while access is enabled) or to the mode register restarts timing. The first tick comes D cycles after the write edge, and bit index 0 begins there.
- R9: The bit and sample strobes are only ever asserted together with an oversample tick.
- R10: Every writable register reads back the value written (only the low 2 bits for mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| os_tick | output | 1 | Oversample tick |
| bit_strobe | output | 1 | Last tick of a bit period |
| sample_strobe | output | 1 | Receive sampling tick |

## Verification
On every cycle the embedded assertions check several properties. The strobes must coincide with a tick, a divisor of 0 or 1 must tick every cycle, and a restart must clear both counters. A locked divisor latch must hold its value, and the bit counter must stay within the 16-tick range outside the programmable mode. Exact tick spacing, strobe positions for each mode and sample point, and read-back values can be shown only by the bench. It sweeps divisors, all four modes and several count/point pairs, and compares each cycle against positions it computes arithmetically.

// File: rtl/uabt_pkg.sv
// Shared definitions for the UART baud timing generator.
// Assumes a byte-wide register port with a 3-bit address.
package uabt_pkg;

    typedef enum logic [1:0] {
        MODE_STD16 = 2'd0,
        MODE_RSVD  = 2'd1,
        MODE_QUAD  = 2'd2,
        MODE_PROG  = 2'd3
    } os_mode_e;

    localparam logic [2:0] ADR_DIV_LO = 3'd0;
    localparam logic [2:0] ADR_DIV_HI = 3'd1;
    localparam logic [2:0] ADR_LCTL   = 3'd3;
    localparam logic [2:0] ADR_MODE   = 3'd4;
    localparam logic [2:0] ADR_TCNT   = 3'd5;
    localparam logic [2:0] ADR_SPNT   = 3'd6;

    localparam int LATCH_BIT = 7;

endpackage

// File: rtl/uabt_regs.sv
// Register file: line control, latch-gated divisor bytes, mode, tick count
// and sample point. Produces a restart pulse for divisor and mode writes.
// Assumes a single-cycle write strobe and a combinational read.
module uabt_regs
    import uabt_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [2:0]       addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output logic [DIV_W-1:0] div_q,
    output os_mode_e         mode_q,
    output logic [CNT_W-1:0] tcnt_q,
    output logic [CNT_W-1:0] spnt_q,
    output logic             restart
);
    localparam int HI_W = DIV_W - 8;

    logic [7:0] lctl_q;
    logic       latch_open;
    logic       wr_lo, wr_hi, wr_mode;

    assign latch_open = lctl_q[LATCH_BIT];
    assign wr_lo   = we && latch_open && (addr == ADR_DIV_LO);
    assign wr_hi   = we && latch_open && (addr == ADR_DIV_HI);
    assign wr_mode = we && (addr == ADR_MODE);
    assign restart = wr_lo || wr_hi || wr_mode;

    // Register storage updated by the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lctl_q <= 8'h00;
            div_q  <= DIV_W'(1);
            mode_q <= MODE_STD16;
            tcnt_q <= '0;
            spnt_q <= '1;
        end else begin
            if (wr_lo)
                div_q[7:0] <= wdata;
            if (wr_hi)
                div_q[DIV_W-1:8] <= wdata[HI_W-1:0];
            if (wr_mode)
                mode_q <= os_mode_e'(wdata[1:0]);
            if (we && addr == ADR_LCTL)
                lctl_q <= wdata;
            if (we && addr == ADR_TCNT)
                tcnt_q <= wdata[CNT_W-1:0];
            if (we && addr == ADR_SPNT)
                spnt_q <= wdata[CNT_W-1:0];
        end
    end

    // Read multiplexer; divisor visible only while the latch bit is set.
    always_comb begin
        rdata = 8'h00;
        unique case (addr)
            ADR_DIV_LO: if (latch_open) rdata = div_q[7:0];
            ADR_DIV_HI: if (latch_open) rdata = 8'(div_q[DIV_W-1:8]);
            ADR_LCTL:   rdata = lctl_q;
            ADR_MODE:   rdata = {6'd0, mode_q};
            ADR_TCNT:   rdata = 8'(tcnt_q);
            ADR_SPNT:   rdata = 8'(spnt_q);
            default:    rdata = 8'h00;
        endcase
    end

    // R2: a locked latch keeps the divisor through writes to its addresses.
    a_r2_div_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !latch_open && (addr == ADR_DIV_LO || addr == ADR_DIV_HI))
        |=> $stable(div_q));

endmodule

// File: rtl/uabt_prescaler.sv
// Divides the system clock by the programmed divisor into oversample ticks.
// Assumes a divisor of zero is to be handled as one.
module uabt_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_in,
    output logic             tick
);
    logic [DIV_W-1:0] pre_cnt;
    logic [DIV_W-1:0] last_idx;

    assign last_idx = (div_in == '0) ? '0 : div_in - DIV_W'(1);
    assign tick     = (pre_cnt >= last_idx);

    // Clock-cycle counter within one tick period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            pre_cnt <= '0;
        else if (tick)
            pre_cnt <= '0;
        else
            pre_cnt <= pre_cnt + DIV_W'(1);
    end

    // R3: divisor 0 or 1 ticks on every cycle.
    a_r3_unit_div_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (div_in <= DIV_W'(1)) |-> tick);

    // R8: restart returns the phase counter to zero.
    a_r8_pre_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pre_cnt == '0));

endmodule

// File: rtl/uabt_bitcnt.sv
// Counts ticks within a bit period for the selected mode and issues the
// bit-boundary and sample strobes. Assumes ticks arrive as single-cycle pulses.
module uabt_bitcnt
    import uabt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    input  os_mode_e         mode,
    input  logic [CNT_W-1:0] tcnt,
    input  logic [CNT_W-1:0] spnt,
    output logic             bit_strobe,
    output logic             sample_strobe
);
    localparam logic [CNT_W-1:0] STD_LAST = CNT_W'(15);
    localparam logic [CNT_W-1:0] STD_MID  = CNT_W'(7);
    localparam logic [CNT_W-1:0] QUAD_LAST = CNT_W'(3);
    localparam logic [CNT_W-1:0] QUAD_MID  = CNT_W'(1);

    logic [CNT_W-1:0] bit_cnt;
    logic [CNT_W-1:0] last_idx;
    logic [CNT_W-1:0] samp_idx;

    // Per-mode period end and sampling index.
    always_comb begin
        unique case (mode)
            MODE_QUAD: begin
                last_idx = QUAD_LAST;
                samp_idx = QUAD_MID;
            end
            MODE_PROG: begin
                last_idx = tcnt;
                samp_idx = spnt;
            end
            default: begin
                last_idx = STD_LAST;
                samp_idx = STD_MID;
            end
        endcase
    end

    assign bit_strobe    = tick && (bit_cnt == last_idx);
    assign sample_strobe = tick && (bit_cnt == samp_idx);

    // Tick index within the current bit period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            bit_cnt <= '0;
        else if (tick)
            bit_cnt <= (bit_cnt >= last_idx) ? '0 : bit_cnt + CNT_W'(1);
    end

    // R9: strobes only accompany a tick.
    a_r9_bit_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |-> tick);
    a_r9_sample_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |-> tick);

    // R4: fixed modes keep the index inside 16 ticks.
    a_r4_fixed_range: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_PROG) |-> (bit_cnt < CNT_W'(16)));

    // R8: restart returns the bit index to zero.
    a_r8_bit_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (bit_cnt == '0));

endmodule

// File: rtl/uart_baud_timer.sv
// Top of the UART baud timing generator: register file, clock prescaler
// and per-bit counter. Assumes one synchronous clock domain.
module uart_baud_timer
    import uabt_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int CNT_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       os_tick,
    output logic       bit_strobe,
    output logic       sample_strobe
);
    logic [DIV_W-1:0] div_q;
    os_mode_e         mode_q;
    logic [CNT_W-1:0] tcnt_q;
    logic [CNT_W-1:0] spnt_q;
    logic             restart;

    uabt_regs #(.DIV_W(DIV_W), .CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .div_q(div_q),
        .mode_q(mode_q), .tcnt_q(tcnt_q), .spnt_q(spnt_q), .restart(restart)
    );

    uabt_prescaler #(.DIV_W(DIV_W)) pre_i (
        .clk(clk), .rst_n(rst_n), .restart(restart), .div_in(div_q),
        .tick(os_tick)
    );

    uabt_bitcnt #(.CNT_W(CNT_W)) bit_i (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tick(os_tick),
        .mode(mode_q), .tcnt(tcnt_q), .spnt(spnt_q),
        .bit_strobe(bit_strobe), .sample_strobe(sample_strobe)
    );

endmodule

// File: tb/uart_baud_timer_tb_top.sv
module uart_baud_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       os_tick, bit_strobe, sample_strobe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_baud_timer dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .os_tick(os_tick),
        .bit_strobe(bit_strobe), .sample_strobe(sample_strobe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input logic [2:0] a, input int exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata == 8'(exp), req, reg_rdata, exp);
    endtask

    // Compare outputs cycle by cycle from the cycle after a restart write.
    task automatic measure(input int div, input int mode, input int tcnt,
                           input int spnt, input string req);
        int d = (div == 0) ? 1 : div;
        int r = (mode == 3) ? tcnt + 1 : (mode == 2) ? 4 : 16;
        int sp = (mode == 3) ? spnt : (mode == 2) ? 1 : 7;
        int n = d * r * 2 + 3;
        for (int c = 0; c < n; c++) begin
            bit et = ((c % d) == d - 1);
            int j = c / d;
            bit eb = et && ((j % r) == r - 1);
            bit es = et && ((j % r) == sp);
            if (c != 0) @(negedge clk);
            check(os_tick == et, {req, " R3 tick"}, os_tick, et);
            check(bit_strobe == eb, {req, " bit strobe"}, bit_strobe, eb);
            check(sample_strobe == es, {req, " sample strobe"}, sample_strobe, es);
        end
    endtask

    task automatic configure(input int div, input int mode, input int tcnt, input int spnt);
        wr(3'd3, 8'h83);
        wr(3'd0, 8'(div));
        wr(3'd1, 8'(div >> 8));
        wr(3'd3, 8'h03);
        wr(3'd5, 8'(tcnt));
        wr(3'd6, 8'(spnt));
        wr(3'd4, 8'(mode));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int divs[5] = '{0, 1, 2, 3, 7};
        int tcs[5]  = '{0, 2, 7, 15, 4};
        int sps[5]  = '{255, 0, 3, 7, 9};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values (divisor read through the latch).
        rd_check(3'd3, 8'h00, "R1 line control");
        rd_check(3'd4, 0, "R1 mode");
        rd_check(3'd5, 0, "R1 tick count");
        rd_check(3'd6, 8'hFF, "R1 sample point");
        rd_check(3'd0, 0, "R2 divisor hidden");
        wr(3'd3, 8'h80);
        rd_check(3'd0, 1, "R1 divisor low");
        rd_check(3'd1, 0, "R1 divisor high");

        // R2 locked latch ignores divisor writes.
        wr(3'd3, 8'h00);
        wr(3'd0, 8'h09);
        wr(3'd1, 8'h05);
        wr(3'd3, 8'h80);
        rd_check(3'd0, 1, "R2 divisor low locked");
        rd_check(3'd1, 0, "R2 divisor high locked");

        // R10 read-back.
        wr(3'd0, 8'hA5);
        wr(3'd1, 8'h3C);
        rd_check(3'd0, 8'hA5, "R10 divisor low");
        rd_check(3'd1, 8'h3C, "R10 divisor high");
        wr(3'd4, 8'hFE);
        rd_check(3'd4, 2, "R10 mode low bits");
        wr(3'd5, 8'h5A);
        rd_check(3'd5, 8'h5A, "R10 tick count");
        wr(3'd6, 8'h21);
        rd_check(3'd6, 8'h21, "R10 sample point");

        // Sweep: fixed modes (R4, R5, R7 with sample point 3) and R6.
        foreach (divs[i]) begin
            for (int m = 0; m < 3; m++) begin
                configure(divs[i], m, 5, 3);
                measure(divs[i], m, 5, 3, (m == 2) ? "R5/R7" : "R4/R7");
            end
            foreach (tcs[k]) begin
                configure(divs[i], 3, tcs[k], sps[k]);
                measure(divs[i], 3, tcs[k], sps[k], "R6");
            end
        end

        // R8: divisor-byte write alone restarts timing mid-run.
        configure(3, 0, 0, 0);
        repeat (11) @(negedge clk);
        wr(3'd3, 8'h83);
        wr(3'd0, 8'd2);
        measure(2, 0, 0, 0, "R8 divisor restart");
        repeat (5) @(negedge clk);
        wr(3'd1, 8'd0);
        measure(2, 0, 0, 0, "R8 high byte restart");

        // Divisor above 255 uses the high byte.
        wr(3'd0, 8'd1);
        wr(3'd1, 8'd1);
        wr(3'd4, 8'd2);
        measure(257, 2, 0, 0, "R3 wide divisor");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule